// File: doc/BRIEF.md
# Micro-Operation Codeword Sequencer

The sequencer sits between a timing unit that fires micro-operation triggers at exact cycles and a pulse playback unit that plays one primitive pulse per codeword. Each trigger carries a micro-operation ID. For a composite operation, the block looks up a programmed list of steps for that ID. Each step holds a delay and a codeword. The block then plays the list out as a train of codeword strobes, so every codeword leaves at a fixed cycle offset from the trigger. For example, a Z operation can be built as codeword 1 at once, then codeword 4 four cycles later.

A configuration port loads the step table and a small control word per ID. The control word holds the index of the final step and a bypass bit. An ID marked as bypass is a primitive operation: its ID goes straight out as the codeword, with no table lookup, at the same latency as the first step of a composite sequence. A trigger that arrives while an earlier sequence still has codewords to send cuts that sequence short and starts the new one. In that case the block pulses an overlap flag.

Top module: `uop_cw_sequencer`

## Requirements
- R1: After reset, `cw_valid` and `overlap` are low, and no codeword strobe appears until a trigger is accepted.
- R2: A trigger presented in cycle c (with no trigger in cycle c+1) yields its first codeword with `cw_valid` high in cycle c+2. The delay stored with step 0 is ignored.
- R3: Step j (j ≥ 1) is strobed exactly d cycles after the strobe of step j−1, where d is that step's stored delay. A stored delay of 0 behaves as 1.
- R4: The control word's final-step field F (width log2 of the step count) makes the sequence exactly F+1 codewords long. No strobe follows the last one until a new trigger.
- R5: For an ID whose bypass bit is 1, one strobe appears in cycle c+2. Its `cw_out` is the trigger ID zero-extended, whatever the step table holds.
- R6: A trigger accepted while an earlier sequence still has unsent codewords (including its first) drops all of them, including any due in that same cycle, and starts the new sequence. `overlap` is high for exactly cycle c+1.
- R7: A trigger accepted after the previous sequence has sent its last codeword leaves `overlap` low.
- R8: A step write stores `cfg_delay` and `cfg_cw` at step `cfg_step` of ID `cfg_id`. A control write stores `cfg_last` and `cfg_bypass` for `cfg_id`. A trigger uses the contents written in earlier cycles.
- R9: Each codeword is strobed for exactly one cycle. Consecutive cycles of `cw_valid` occur only for steps with delay 0 or 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_step_we | input | 1 | Step table write strobe |
| cfg_ctl_we | input | 1 | Per-ID control word write strobe |
| cfg_id | input | ID_W | ID addressed by a write |
| cfg_step | input | STEP_W | Step index for a step write |
| cfg_delay | input | DLY_W | Delay in cycles from the previous step |
| cfg_cw | input | CW_W | Codeword of the step |
| cfg_last | input | STEP_W | Index of the final step of the ID |
| cfg_bypass | input | 1 | 1 = ID is a primitive, pass it through |
| trig_valid | input | 1 | Micro-operation trigger |
| trig_id | input | ID_W | ID of the triggered micro-operation |
| cw_out | output | CW_W | Codeword to the playback unit |
| cw_valid | output | 1 | One-cycle strobe qualifying `cw_out` |
| overlap | output | 1 | Pulses when a trigger aborts a running sequence |

## Verification
The bench drives an eight-step sequence that mixes delays of 0, 1 and larger values, plus a nonzero step-0 delay. A design that mishandles zero delays would stall or emit twice, and one that honoured the step-0 delay would strobe late. It aborts a long sequence midway and fires two bypass triggers in adjacent cycles. A design that let a stale codeword through, or that missed a pending first codeword when deciding `overlap`, would show an unexpected strobe or a wrong flag. It then shortens a sequence by reprogramming the final-step field and uses the highest ID. An off-by-one length or an address wrap would show up there as an extra or missing codeword.

// File: rtl/seq_pkg.sv
package seq_pkg;
  typedef enum logic [1:0] {
    ENG_IDLE  = 2'd0,
    ENG_FIRST = 2'd1,
    ENG_RUN   = 2'd2
  } eng_state_t;
endpackage

// File: rtl/seq_step_ram.sv
module seq_step_ram #(
  parameter int ADDR_W = 7,
  parameter int DATA_W = 16
) (
  input  logic              clk,
  input  logic              we,
  input  logic [ADDR_W-1:0] waddr,
  input  logic [DATA_W-1:0] wdata,
  input  logic [ADDR_W-1:0] raddr,
  output logic [DATA_W-1:0] rdata
);
  localparam int DEPTH = 1 << ADDR_W;

  logic [DATA_W-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
    rdata <= mem[raddr];
  end
endmodule

// File: rtl/seq_ctl_regs.sv
module seq_ctl_regs #(
  parameter int N_IDS  = 16,
  parameter int ID_W   = 4,
  parameter int STEP_W = 3
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              we,
  input  logic [ID_W-1:0]   wid,
  input  logic [STEP_W-1:0] wlast,
  input  logic              wbyp,
  input  logic [ID_W-1:0]   rid,
  output logic [STEP_W-1:0] rlast,
  output logic              rbyp
);
  logic [N_IDS-1:0][STEP_W-1:0] last_vec;
  logic [N_IDS-1:0]             byp_vec;

  for (genvar g = 0; g < N_IDS; g++) begin : g_id
    logic [STEP_W-1:0] last_r;
    logic              byp_r;
    always_ff @(posedge clk) begin
      if (rst) begin
        last_r <= '0;
        byp_r  <= 1'b0;
      end else if (we && (wid == ID_W'(g))) begin
        last_r <= wlast;
        byp_r  <= wbyp;
      end
    end
    assign last_vec[g] = last_r;
    assign byp_vec[g]  = byp_r;
  end

  assign rlast = last_vec[rid];
  assign rbyp  = byp_vec[rid];
endmodule

// File: rtl/seq_engine.sv
module seq_engine
  import seq_pkg::*;
#(
  parameter int ID_W   = 4,
  parameter int STEP_W = 3,
  parameter int CW_W   = 8,
  parameter int DLY_W  = 8
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    trig_valid,
  input  logic [ID_W-1:0]         trig_id,
  input  logic [STEP_W-1:0]       sel_last,
  input  logic                    sel_byp,
  input  logic [DLY_W+CW_W-1:0]   rd_data,
  output logic [ID_W+STEP_W-1:0]  rd_addr,
  output logic [CW_W-1:0]         cw_out,
  output logic                    cw_valid,
  output logic                    overlap
);
  eng_state_t        state;
  logic [ID_W-1:0]   cur_id;
  logic [STEP_W-1:0] idx;
  logic [STEP_W-1:0] last_idx;
  logic [DLY_W-1:0]  cnt;
  logic              byp_r;
  logic [CW_W-1:0]   byp_cw;

  logic [DLY_W-1:0]  rd_dly;
  logic [CW_W-1:0]   rd_cw;
  logic [DLY_W-1:0]  eff_dly;
  logic              due;
  logic              at_end;

  assign rd_dly  = rd_data[DLY_W+CW_W-1:CW_W];
  assign rd_cw   = rd_data[CW_W-1:0];
  assign eff_dly = (rd_dly == '0) ? DLY_W'(1) : rd_dly;
  assign due     = (state == ENG_FIRST) || ((state == ENG_RUN) && (cnt >= eff_dly));
  assign at_end  = (idx == last_idx);

  // Prefetch: the step that becomes pending is read at the emission edge.
  always_comb begin
    if (trig_valid)
      rd_addr = {trig_id, {STEP_W{1'b0}}};
    else if (due && !at_end)
      rd_addr = {cur_id, STEP_W'(idx + 1'b1)};
    else
      rd_addr = {cur_id, idx};
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state    <= ENG_IDLE;
      cur_id   <= '0;
      idx      <= '0;
      last_idx <= '0;
      cnt      <= '0;
      byp_r    <= 1'b0;
      byp_cw   <= '0;
      cw_out   <= '0;
      cw_valid <= 1'b0;
      overlap  <= 1'b0;
    end else begin
      cw_valid <= 1'b0;
      overlap  <= 1'b0;
      if (trig_valid) begin
        overlap  <= (state != ENG_IDLE);
        state    <= ENG_FIRST;
        cur_id   <= trig_id;
        idx      <= '0;
        last_idx <= sel_byp ? '0 : sel_last;
        byp_r    <= sel_byp;
        byp_cw   <= CW_W'(trig_id);
      end else if (due) begin
        cw_valid <= 1'b1;
        cw_out   <= byp_r ? byp_cw : rd_cw;
        cnt      <= DLY_W'(1);
        if (at_end) begin
          state <= ENG_IDLE;
        end else begin
          idx   <= STEP_W'(idx + 1'b1);
          state <= ENG_RUN;
        end
      end else if (state == ENG_RUN) begin
        cnt <= cnt + 1'b1;
      end
    end
  end

  AST_FIRST_LATENCY: assert property (@(posedge clk) disable iff (rst)
    trig_valid ##1 !trig_valid |=> cw_valid); // R2

  AST_OVERLAP_CAUSE: assert property (@(posedge clk) disable iff (rst)
    overlap |-> $past(trig_valid)); // R6

  AST_STEP_BOUND: assert property (@(posedge clk) disable iff (rst)
    (state != ENG_IDLE) |-> (idx <= last_idx)); // R4

  AST_IDLE_SILENT: assert property (@(posedge clk) disable iff (rst)
    (state == ENG_IDLE && !trig_valid) |=> !cw_valid); // R1
endmodule

// File: rtl/uop_cw_sequencer.sv
module uop_cw_sequencer #(
  parameter int N_IDS     = 16,
  parameter int MAX_STEPS = 8,
  parameter int CW_W      = 8,
  parameter int DLY_W     = 8,
  localparam int ID_W     = $clog2(N_IDS),
  localparam int STEP_W   = $clog2(MAX_STEPS)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cfg_step_we,
  input  logic              cfg_ctl_we,
  input  logic [ID_W-1:0]   cfg_id,
  input  logic [STEP_W-1:0] cfg_step,
  input  logic [DLY_W-1:0]  cfg_delay,
  input  logic [CW_W-1:0]   cfg_cw,
  input  logic [STEP_W-1:0] cfg_last,
  input  logic              cfg_bypass,
  input  logic              trig_valid,
  input  logic [ID_W-1:0]   trig_id,
  output logic [CW_W-1:0]   cw_out,
  output logic              cw_valid,
  output logic              overlap
);
  localparam int ADDR_W = ID_W + STEP_W;
  localparam int DATA_W = DLY_W + CW_W;

  logic [ADDR_W-1:0] rd_addr;
  logic [DATA_W-1:0] rd_data;
  logic [STEP_W-1:0] sel_last;
  logic              sel_byp;

  seq_step_ram #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_ram (
    .clk   (clk),
    .we    (cfg_step_we),
    .waddr ({cfg_id, cfg_step}),
    .wdata ({cfg_delay, cfg_cw}),
    .raddr (rd_addr),
    .rdata (rd_data)
  );

  seq_ctl_regs #(.N_IDS(N_IDS), .ID_W(ID_W), .STEP_W(STEP_W)) u_ctl (
    .clk   (clk),
    .rst   (rst),
    .we    (cfg_ctl_we),
    .wid   (cfg_id),
    .wlast (cfg_last),
    .wbyp  (cfg_bypass),
    .rid   (trig_id),
    .rlast (sel_last),
    .rbyp  (sel_byp)
  );

  seq_engine #(.ID_W(ID_W), .STEP_W(STEP_W), .CW_W(CW_W), .DLY_W(DLY_W)) u_eng (
    .clk        (clk),
    .rst        (rst),
    .trig_valid (trig_valid),
    .trig_id    (trig_id),
    .sel_last   (sel_last),
    .sel_byp    (sel_byp),
    .rd_data    (rd_data),
    .rd_addr    (rd_addr),
    .cw_out     (cw_out),
    .cw_valid   (cw_valid),
    .overlap    (overlap)
  );

  AST_BYPASS_CW: assert property (@(posedge clk) disable iff (rst)
    (trig_valid && sel_byp) ##1 !trig_valid |=>
      (cw_valid && cw_out == CW_W'($past(trig_id, 2)))); // R5
endmodule

// File: tb/uop_cw_sequencer_bench.sv
module uop_cw_sequencer_bench;
  localparam int N_IDS = 16, MAX_STEPS = 8, CW_W = 8, DLY_W = 8;
  localparam int ID_W = 4, STEP_W = 3;

  logic clk = 1'b0, rst = 1'b1;
  logic cfg_step_we = 0, cfg_ctl_we = 0, cfg_bypass = 0, trig_valid = 0;
  logic [ID_W-1:0] cfg_id = '0, trig_id = '0;
  logic [STEP_W-1:0] cfg_step = '0, cfg_last = '0;
  logic [DLY_W-1:0] cfg_delay = '0;
  logic [CW_W-1:0] cfg_cw = '0;
  logic [CW_W-1:0] cw_out;
  logic cw_valid, overlap;

  uop_cw_sequencer #(.N_IDS(N_IDS), .MAX_STEPS(MAX_STEPS), .CW_W(CW_W), .DLY_W(DLY_W)) u_uop_cw_sequencer (
    .clk(clk), .rst(rst), .cfg_step_we(cfg_step_we), .cfg_ctl_we(cfg_ctl_we),
    .cfg_id(cfg_id), .cfg_step(cfg_step), .cfg_delay(cfg_delay), .cfg_cw(cfg_cw),
    .cfg_last(cfg_last), .cfg_bypass(cfg_bypass), .trig_valid(trig_valid),
    .trig_id(trig_id), .cw_out(cw_out), .cw_valid(cw_valid), .overlap(overlap));

  always #10 clk = ~clk;

  int cyc = 0;
  always @(posedge clk) cyc <= cyc + 1;

  int n_chk = 0, n_err = 0;
  bit done = 0;

  typedef struct { int at; int cw; string tag; } exp_t;
  exp_t q[$];

  int m_dly [N_IDS][MAX_STEPS];
  int m_cw  [N_IDS][MAX_STEPS];
  int m_last[N_IDS];
  bit m_byp [N_IDS];

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s actual=%0d expected=%0d (cycle %0d)", tag, act, exp, cyc);
    end
  endtask

  // Monitor: pops expected codewords as they appear.
  always @(negedge clk) begin
    if (!rst && !done) begin
      while (q.size() > 0 && q[0].at < cyc) begin
        chk(1'b0, {q[0].tag, " missing codeword"}, -1, q[0].cw);
        void'(q.pop_front());
      end
      if (cw_valid) begin
        if (q.size() > 0 && q[0].at == cyc) begin
          chk(cw_out == CW_W'(q[0].cw), q[0].tag, cw_out, q[0].cw);
          void'(q.pop_front());
        end else begin
          chk(1'b0, "R4 R9 unexpected strobe", cw_out, -1);
        end
      end
    end
  end

  task automatic write_step(input int id, input int st, input int d, input int cw);
    cfg_step_we = 1; cfg_id = ID_W'(id); cfg_step = STEP_W'(st);
    cfg_delay = DLY_W'(d); cfg_cw = CW_W'(cw);
    m_dly[id][st] = d; m_cw[id][st] = cw;
    @(negedge clk); cfg_step_we = 0;
  endtask

  task automatic write_ctl(input int id, input int last, input bit byp);
    cfg_ctl_we = 1; cfg_id = ID_W'(id); cfg_last = STEP_W'(last); cfg_bypass = byp;
    m_last[id] = last; m_byp[id] = byp;
    @(negedge clk); cfg_ctl_we = 0;
  endtask

  // Driver: called at a negedge; trigger sampled at the next edge (cycle t0).
  task automatic fire(input int id, input string ovl_tag);
    int t0, t;
    bit exp_ovl;
    exp_t keep[$];
    exp_t e;
    trig_valid = 1; trig_id = ID_W'(id);
    t0 = cyc + 1;
    exp_ovl = 0;
    foreach (q[i]) if (q[i].at >= t0) exp_ovl = 1; else keep.push_back(q[i]);
    q = keep;
    t = t0 + 1;
    if (m_byp[id]) begin
      e.at = t; e.cw = id; e.tag = "R5 bypass codeword"; q.push_back(e);
    end else begin
      e.at = t; e.cw = m_cw[id][0]; e.tag = "R2 first codeword"; q.push_back(e);
      for (int j = 1; j <= m_last[id]; j++) begin
        t += (m_dly[id][j] == 0) ? 1 : m_dly[id][j];
        e.at = t; e.cw = m_cw[id][j]; e.tag = "R3 step codeword"; q.push_back(e);
      end
    end
    @(posedge clk); @(negedge clk);
    chk(overlap == exp_ovl, ovl_tag, overlap, exp_ovl);
    trig_valid = 0;
  endtask

  task automatic wait_cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin
    #(20 * 100000);
    if (!done) begin
      done = 1;
      n_chk++; n_err++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
      $finish;
    end
  end

  initial begin
    for (int i = 0; i < N_IDS; i++) begin
      m_last[i] = 0; m_byp[i] = 0;
      for (int j = 0; j < MAX_STEPS; j++) begin m_dly[i][j] = 0; m_cw[i][j] = 0; end
    end
    repeat (3) @(negedge clk);
    rst = 0;
    // R1: quiet after reset
    for (int k = 0; k < 3; k++) begin
      chk(cw_valid == 0, "R1 cw_valid after reset", cw_valid, 0);
      chk(overlap == 0, "R1 overlap after reset", overlap, 0);
      @(negedge clk);
    end
    // R8: program composite Z = (0,1);(4,4) on ID 3
    write_step(3, 0, 0, 1);
    write_step(3, 1, 4, 4);
    write_ctl(3, 1, 0);
    fire(3, "R7 overlap idle");
    wait_cyc(10);
    // R2 R3 R9: eight steps, nonzero step-0 delay, zero and unit delays
    write_step(5, 0, 7, 10);
    write_step(5, 1, 3, 11);
    write_step(5, 2, 0, 12);
    write_step(5, 3, 1, 13);
    write_step(5, 4, 2, 14);
    write_step(5, 5, 5, 15);
    write_step(5, 6, 1, 16);
    write_step(5, 7, 4, 17);
    write_ctl(5, 7, 0);
    fire(5, "R7 overlap idle");
    wait_cyc(25);
    // R5: bypass ignores table contents
    write_step(9, 0, 0, 200);
    write_ctl(9, 3, 1);
    fire(9, "R7 overlap idle");
    wait_cyc(5);
    // R6: abort mid-sequence
    fire(5, "R7 overlap idle");
    wait_cyc(4);
    fire(3, "R6 overlap on abort");
    wait_cyc(12);
    // R6: back-to-back bypass triggers, first still pending
    write_ctl(2, 0, 1);
    fire(9, "R7 overlap idle");
    fire(2, "R6 overlap pending first");
    wait_cyc(6);
    // R4: shorten ID 5 to three steps
    write_ctl(5, 2, 0);
    fire(5, "R7 overlap idle");
    wait_cyc(20);
    // R4: highest ID, single step
    write_step(15, 0, 9, 77);
    write_ctl(15, 0, 0);
    fire(15, "R7 overlap idle");
    wait_cyc(10);
    chk(q.size() == 0, "R4 leftover expectations", q.size(), 0);
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  end
endmodule